// File: doc/BRIEF.md
# Loop Address Writeback Unit

This unit sits beside a transfer engine that walks descriptors. When an inner transfer loop ends, or the whole outer loop ends, it computes the source and destination addresses to write back into the descriptor. It also reports the byte count held in the descriptor's count word.

The count word can be read in two ways, chosen by a global mapping enable. With mapping off, the whole word is the count. With mapping on, the two top bits select whether a shared signed offset is applied to the source address, the destination address, both or neither. When either of those bits is set, the word splits into a 20-bit offset and a short 10-bit count. When the whole outer loop ends, the offset is ignored and a separate last-adjust value is added to each address.

Results are registered. A one-cycle valid strobe marks each new result, and the registers hold their values until the next completion event.

Top module: `addr_wb_top`

## Requirements
- R1: While `rstN` is low, and after it rises until the first completion event, `wbValid` is 0 and `srcNext`, `dstNext` and `byteCount` are all 0.
- R2: A clock edge that samples `minorDone` or `majorDone` high loads new results. These appear after that same edge with `wbValid` high for that cycle. An edge that samples neither leaves `wbValid` low for the next cycle.
- R3: With no completion event, `srcNext`, `dstNext` and `byteCount` keep their last values, whatever the other inputs do.
- R4: With `mapEn` = 0, `byteCount` equals all 32 bits of `countWord`. On an inner-loop completion, `srcNext` = `srcFinal` and `dstNext` = `dstFinal`.
- R5: With `mapEn` = 1 and `countWord` bits 31 and 30 both 0, `byteCount` is bits 29:0 zero-extended, and no offset is applied.
- R6: With `mapEn` = 1 and bit 31 or bit 30 of `countWord` set, `byteCount` is bits 9:0 zero-extended. The offset is bits 29:10 read as a 20-bit two's-complement value and sign-extended to 32 bits.
- R7: On an inner-loop completion with `mapEn` = 1, the offset is added to `srcFinal` when bit 31 is set and to `dstFinal` when bit 30 is set. A single offset value serves both addresses.
- R8: When `majorDone` is high, whether or not `minorDone` is also high: `srcNext` = `srcFinal` + `srcLast` and `dstNext` = `dstFinal` + `dstLast`. The offset is ignored, and `byteCount` is still decoded as in R4 to R6.
- R9: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapEn | input | 1 | Global enable for the offset-mapped count word layout |
| minorDone | input | 1 | Inner loop completion event |
| majorDone | input | 1 | Outer loop completion event |
| srcFinal | input | 32 | Source address at the end of the loop |
| dstFinal | input | 32 | Destination address at the end of the loop |
| countWord | input | 32 | Descriptor byte-count word |
| srcLast | input | 32 | Source last-adjust value |
| dstLast | input | 32 | Destination last-adjust value |
| wbValid | output | 1 | One-cycle strobe marking fresh results |
| srcNext | output | 32 | Source address to write back |
| dstNext | output | 32 | Destination address to write back |
| byteCount | output | 32 | Decoded byte count |

## Verification
The checker tests every cycle that the strobe follows each completion event by one edge and that the outputs hold when no event occurs. It also checks the address arithmetic for the outer-loop case and for each inner-loop case, with and without mapping, including the per-address offset selection. It checks the count decode in all three layouts. Only the bench scenarios show the reset values, behaviour after a reset in mid-run, back-to-back events, wrap-around at the ends of the address space, and the most negative offset.

// File: rtl/addr_wb_pkg.sv
package addr_wb_pkg;

  // Layout of the count word as chosen by the control path
  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,  // mapping off: whole word is the count
    FMT_LONG  = 2'd1,  // mapping on, both enables clear
    FMT_SHORT = 2'd2   // mapping on, an enable set: offset + short count
  } cntFmt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    load;       // capture new results this edge
    logic    useLast;    // outer loop done: add last-adjust values
    logic    addSrcOff;  // add shared offset to source address
    logic    addDstOff;  // add shared offset to destination address
    cntFmt_t fmt;        // count word layout
  } wbStrobe_t;

endpackage

// File: rtl/addr_wb_ctrl.sv
module addr_wb_ctrl
  import addr_wb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mapEn,
  input  logic       minorDone,
  input  logic       majorDone,
  input  logic       srcSel,
  input  logic       dstSel,
  output wbStrobe_t  strobe,
  output logic       wbValid
);

  logic anySel;
  logic event_;

  assign anySel = srcSel | dstSel;
  assign event_ = minorDone | majorDone;

  always_comb begin
    strobe = '0;
    strobe.load    = event_;
    strobe.useLast = majorDone;
    if (!mapEn) begin
      strobe.fmt = FMT_FULL;
    end else if (anySel) begin
      strobe.fmt = FMT_SHORT;
    end else begin
      strobe.fmt = FMT_LONG;
    end
    // offsets only on an inner-loop end that is not also the outer end
    strobe.addSrcOff = mapEn & srcSel & ~majorDone;
    strobe.addDstOff = mapEn & dstSel & ~majorDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbValid <= 1'b0;
    end else begin
      wbValid <= event_;
    end
  end

endmodule

// File: rtl/addr_wb_datapath.sv
module addr_wb_datapath
  import addr_wb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 20,
  parameter int SHORT_CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  wbStrobe_t         strobe,
  input  logic [ADDR_W-1:0] srcFinal,
  input  logic [ADDR_W-1:0] dstFinal,
  input  logic [WORD_W-1:0] countWord,
  input  logic [ADDR_W-1:0] srcLast,
  input  logic [ADDR_W-1:0] dstLast,
  output logic [ADDR_W-1:0] srcNext,
  output logic [ADDR_W-1:0] dstNext,
  output logic [WORD_W-1:0] byteCount
);

  localparam int LONG_CNT_W = WORD_W - 2;
  localparam int OFF_LSB    = SHORT_CNT_W;
  localparam int OFF_MSB    = SHORT_CNT_W + OFF_W - 1;
  localparam int LANES      = 2;

  logic [ADDR_W-1:0] offSext;
  logic [WORD_W-1:0] cntDec;
  logic [WORD_W-1:0] cntQ;
  logic [ADDR_W-1:0] finalA [LANES];
  logic [ADDR_W-1:0] lastA  [LANES];
  logic              applyA [LANES];
  logic [ADDR_W-1:0] nextQ  [LANES];

  assign offSext = {{(ADDR_W - OFF_W){countWord[OFF_MSB]}}, countWord[OFF_MSB:OFF_LSB]};

  always_comb begin
    unique case (strobe.fmt)
      FMT_SHORT: cntDec = {{(WORD_W - SHORT_CNT_W){1'b0}}, countWord[SHORT_CNT_W-1:0]};
      FMT_LONG:  cntDec = {2'b00, countWord[LONG_CNT_W-1:0]};
      default:   cntDec = countWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= cntDec;
    end
  end

  assign finalA[0] = srcFinal;
  assign finalA[1] = dstFinal;
  assign lastA[0]  = srcLast;
  assign lastA[1]  = dstLast;
  assign applyA[0] = strobe.addSrcOff;
  assign applyA[1] = strobe.addDstOff;

  // one identical adder lane per address
  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    logic [ADDR_W-1:0] addend;
    logic [ADDR_W-1:0] sum;

    always_comb begin
      if (strobe.useLast) begin
        addend = lastA[lane];
      end else if (applyA[lane]) begin
        addend = offSext;
      end else begin
        addend = '0;
      end
    end

    assign sum = finalA[lane] + addend;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nextQ[lane] <= '0;
      end else if (strobe.load) begin
        nextQ[lane] <= sum;
      end
    end
  end

  assign srcNext   = nextQ[0];
  assign dstNext   = nextQ[1];
  assign byteCount = cntQ;

endmodule

// File: rtl/addr_wb_top.sv
module addr_wb_top
  import addr_wb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 20,
  parameter int SHORT_CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapEn,
  input  logic              minorDone,
  input  logic              majorDone,
  input  logic [ADDR_W-1:0] srcFinal,
  input  logic [ADDR_W-1:0] dstFinal,
  input  logic [WORD_W-1:0] countWord,
  input  logic [ADDR_W-1:0] srcLast,
  input  logic [ADDR_W-1:0] dstLast,
  output logic              wbValid,
  output logic [ADDR_W-1:0] srcNext,
  output logic [ADDR_W-1:0] dstNext,
  output logic [WORD_W-1:0] byteCount
);

  wbStrobe_t strobe;

  addr_wb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mapEn     (mapEn),
    .minorDone (minorDone),
    .majorDone (majorDone),
    .srcSel    (countWord[WORD_W-1]),
    .dstSel    (countWord[WORD_W-2]),
    .strobe    (strobe),
    .wbValid   (wbValid)
  );

  addr_wb_datapath #(
    .ADDR_W      (ADDR_W),
    .WORD_W      (WORD_W),
    .OFF_W       (OFF_W),
    .SHORT_CNT_W (SHORT_CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .srcFinal  (srcFinal),
    .dstFinal  (dstFinal),
    .countWord (countWord),
    .srcLast   (srcLast),
    .dstLast   (dstLast),
    .srcNext   (srcNext),
    .dstNext   (dstNext),
    .byteCount (byteCount)
  );

endmodule

// File: rtl/addr_wb_checks.sv
module addr_wb_checks #(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int OFF_W       = 20,
  parameter int SHORT_CNT_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              mapEn,
  input logic              minorDone,
  input logic              majorDone,
  input logic [ADDR_W-1:0] srcFinal,
  input logic [ADDR_W-1:0] dstFinal,
  input logic [WORD_W-1:0] countWord,
  input logic [ADDR_W-1:0] srcLast,
  input logic [ADDR_W-1:0] dstLast,
  input logic              wbValid,
  input logic [ADDR_W-1:0] srcNext,
  input logic [ADDR_W-1:0] dstNext,
  input logic [WORD_W-1:0] byteCount
);

  localparam int OFF_LSB = SHORT_CNT_W;
  localparam int OFF_MSB = SHORT_CNT_W + OFF_W - 1;

  logic              evt;
  logic              anySel;
  logic [ADDR_W-1:0] offExp;

  assign evt    = minorDone | majorDone;
  assign anySel = countWord[WORD_W-1] | countWord[WORD_W-2];
  assign offExp = {{(ADDR_W - OFF_W){countWord[OFF_MSB]}}, countWord[OFF_MSB:OFF_LSB]};

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    evt |=> wbValid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !evt |=> !wbValid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !evt |=> ($stable(srcNext) && $stable(dstNext) && $stable(byteCount)));

  assert_full_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (evt && !mapEn) |=> (byteCount == $past(countWord)));

  assert_no_offset_unmapped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (minorDone && !majorDone && !mapEn) |=>
      (srcNext == $past(srcFinal) && dstNext == $past(dstFinal)));

  assert_long_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evt && mapEn && !anySel) |=>
      (byteCount == {2'b00, $past(countWord[WORD_W-3:0])}));

  assert_short_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    (evt && mapEn && anySel) |=>
      (byteCount == {{(WORD_W - SHORT_CNT_W){1'b0}}, $past(countWord[SHORT_CNT_W-1:0])}));

  assert_src_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (minorDone && !majorDone && mapEn) |=>
      (srcNext == $past(srcFinal) + ($past(countWord[WORD_W-1]) ? $past(offExp) : '0)));

  assert_dst_offset_R7: assert property (@(posedge clk) disable iff (!rstN)
    (minorDone && !majorDone && mapEn) |=>
      (dstNext == $past(dstFinal) + ($past(countWord[WORD_W-2]) ? $past(offExp) : '0)));

  assert_last_adjust_R8: assert property (@(posedge clk) disable iff (!rstN)
    majorDone |=> (srcNext == $past(srcFinal) + $past(srcLast) &&
                   dstNext == $past(dstFinal) + $past(dstLast)));

endmodule

bind addr_wb_top addr_wb_checks #(
  .ADDR_W      (ADDR_W),
  .WORD_W      (WORD_W),
  .OFF_W       (OFF_W),
  .SHORT_CNT_W (SHORT_CNT_W)
) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .mapEn     (mapEn),
  .minorDone (minorDone),
  .majorDone (majorDone),
  .srcFinal  (srcFinal),
  .dstFinal  (dstFinal),
  .countWord (countWord),
  .srcLast   (srcLast),
  .dstLast   (dstLast),
  .wbValid   (wbValid),
  .srcNext   (srcNext),
  .dstNext   (dstNext),
  .byteCount (byteCount)
);

// File: tb/test_addr_wb_top.sv
module test_addr_wb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        mapEn;
  logic        minorDone;
  logic        majorDone;
  logic [31:0] srcFinal;
  logic [31:0] dstFinal;
  logic [31:0] countWord;
  logic [31:0] srcLast;
  logic [31:0] dstLast;
  logic        wbValid;
  logic [31:0] srcNext;
  logic [31:0] dstNext;
  logic [31:0] byteCount;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  addr_wb_top i_addr_wb_top (
    .clk       (clk),
    .rstN      (rstN),
    .mapEn     (mapEn),
    .minorDone (minorDone),
    .majorDone (majorDone),
    .srcFinal  (srcFinal),
    .dstFinal  (dstFinal),
    .countWord (countWord),
    .srcLast   (srcLast),
    .dstLast   (dstLast),
    .wbValid   (wbValid),
    .srcNext   (srcNext),
    .dstNext   (dstNext),
    .byteCount (byteCount)
  );

  typedef struct packed {
    logic [15:0] tag;
    logic        map;
    logic        mn;
    logic        mj;
    logic [31:0] sf;
    logic [31:0] df;
    logic [31:0] w;
    logic [31:0] sl;
    logic [31:0] dl;
    logic [31:0] es;
    logic [31:0] ed;
    logic [31:0] ec;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    // R4: mapping off, top bits set yet no offset, full-word count
    '{"R4", 1'b0, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'hC000_0010, 32'h0, 32'h0,
      32'h0000_1000, 32'h0000_2000, 32'hC000_0010},
    // R5: mapping on, enables clear, 30-bit count
    '{"R5", 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'h2000_0040, 32'h0, 32'h0,
      32'h0000_1000, 32'h0000_2000, 32'h2000_0040},
    // R6/R7: source only, offset +0x10, count 8
    '{"R7", 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'h8000_4008, 32'h0, 32'h0,
      32'h0000_1010, 32'h0000_2000, 32'h0000_0008},
    // R6: destination only, offset -4, count 0x3FF
    '{"R6", 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'h7FFF_F3FF, 32'h0, 32'h0,
      32'h0000_1000, 32'h0000_1FFC, 32'h0000_03FF},
    // R7: both, same offset +0x100
    '{"R7", 1'b1, 1'b1, 1'b0, 32'h0000_1000, 32'h0000_2000, 32'hC004_0005, 32'h0, 32'h0,
      32'h0000_1100, 32'h0000_2100, 32'h0000_0005},
    // R8: outer loop end, offset ignored, last-adjust used
    '{"R8", 1'b1, 1'b0, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'hC004_0005, 32'hFFFF_FF00, 32'h0000_0040,
      32'h0000_0F00, 32'h0000_2040, 32'h0000_0005},
    // R9: source offset wraps past the top
    '{"R9", 1'b1, 1'b1, 1'b0, 32'hFFFF_FFF0, 32'h0000_2000, 32'h8000_8001, 32'h0, 32'h0,
      32'h0000_0010, 32'h0000_2000, 32'h0000_0001},
    // R8/R9: both events, last-adjust sums wrap
    '{"R9", 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h8000_0004, 32'h0000_0002,
      32'h0000_0004, 32'h0000_0001, 32'h1234_5678},
    // R6: most negative offset, count 0
    '{"R6", 1'b1, 1'b1, 1'b0, 32'h0010_0000, 32'h0000_2000, 32'hA000_0000, 32'h0, 32'h0,
      32'h0008_0000, 32'h0000_2000, 32'h0000_0000}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    minorDone = 1'b0;
    majorDone = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; mapEn = 1'b0; idle();
    srcFinal = 32'h1111_1111; dstFinal = 32'h2222_2222; countWord = 32'hFFFF_FFFF;
    srcLast = 32'h5; dstLast = 32'h6;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "wbValid", {31'b0, wbValid}, 32'h0);
    chk("R1", "srcNext", srcNext, 32'h0);
    chk("R1", "dstNext", dstNext, 32'h0);
    chk("R1", "byteCount", byteCount, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "srcNext after release", srcNext, 32'h0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      mapEn = VECS[i].map; minorDone = VECS[i].mn; majorDone = VECS[i].mj;
      srcFinal = VECS[i].sf; dstFinal = VECS[i].df; countWord = VECS[i].w;
      srcLast = VECS[i].sl; dstLast = VECS[i].dl;
      @(negedge clk);
      chk("R2", $sformatf("vec %0d wbValid", i), {31'b0, wbValid}, 32'h1);
      chk(string'(VECS[i].tag), $sformatf("vec %0d srcNext", i), srcNext, VECS[i].es);
      chk(string'(VECS[i].tag), $sformatf("vec %0d dstNext", i), dstNext, VECS[i].ed);
      chk(string'(VECS[i].tag), $sformatf("vec %0d byteCount", i), byteCount, VECS[i].ec);
      idle();
      @(negedge clk);
      chk("R2", $sformatf("vec %0d strobe drop", i), {31'b0, wbValid}, 32'h0);
    end

    // R3: inputs change without an event, outputs hold
    mapEn = 1'b1; srcFinal = 32'hDEAD_0000; dstFinal = 32'hBEEF_0000;
    countWord = 32'hC000_7777; srcLast = 32'h9; dstLast = 32'h9;
    repeat (3) @(negedge clk);
    chk("R3", "srcNext hold", srcNext, 32'h0008_0000);
    chk("R3", "dstNext hold", dstNext, 32'h0000_2000);
    chk("R3", "byteCount hold", byteCount, 32'h0000_0000);
    chk("R3", "wbValid low", {31'b0, wbValid}, 32'h0);

    // R2: back-to-back events
    mapEn = 1'b0; minorDone = 1'b1; srcFinal = 32'hA; dstFinal = 32'hB; countWord = 32'h3;
    @(negedge clk);
    chk("R2", "first of pair src", srcNext, 32'hA);
    minorDone = 1'b0; majorDone = 1'b1; srcLast = 32'h10; dstLast = 32'h20; countWord = 32'h4;
    @(negedge clk);
    chk("R2", "second of pair valid", {31'b0, wbValid}, 32'h1);
    chk("R8", "second of pair src", srcNext, 32'h1A);
    chk("R8", "second of pair dst", dstNext, 32'h2B);
    chk("R4", "second of pair count", byteCount, 32'h4);
    idle();
    @(negedge clk);

    // R1: reset in mid-run clears results
    rstN = 1'b0;
    @(negedge clk);
    chk("R1", "mid reset src", srcNext, 32'h0);
    chk("R1", "mid reset count", byteCount, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule